// File: doc/BRIEF.md
# Fractional pulse-swallowing clock enable

This block turns a free-running parent clock into a reduced-rate clock enable. Time is cut into fixed windows of 32 parent cycles. Inside each window the enable is high on exactly (32 − code) cycles and low on the rest, so the enabled rate is parent × (32 − code) / 32. Code 0 gives the full parent rate and code 31 gives one enabled cycle per window. The enabled cycles are spread across the window by a phase accumulator rather than grouped together.

Software changes the rate in two steps. It writes a new code, which is only held. It then issues a commit request (the kick). The commit stages the held code, and the staged code becomes active at the next window boundary, so a window is never cut short. A busy flag stays high for a fixed number of cycles after each commit. Any write made while busy is high is discarded and raises a one-cycle error flag. The active code and its multiplier are visible at the ports, so downstream logic can scale its own counts.

Top module: `pulse_swallow_ce`

## Requirements
- R1: In every aligned 32-cycle window, `ce_out` is high on exactly 32 − `active_code` cycles. Code 0 gives an enable every cycle, and code 31 gives one enable per window.
- R2: Windows are counted from reset release. Let n (0..31) be the position in the window and k = 32 − `active_code`. `ce_out` is high at position n exactly when floor((n+1)·k/32) > floor(n·k/32).
- R3: A write is `wr_valid` high for one cycle. The code field is `wr_data[4:0]` and the kick bit is `wr_data[31]`; all other bits are ignored. An accepted write with the kick bit at 0 only replaces the held code and changes no output.
- R4: An accepted write with the kick bit at 1 stages the held code and ignores its own code field. The staged code becomes `active_code` starting at position 0 of the next window. A commit accepted on the position-31 cycle waits one full window.
- R5: After the edge that accepts a commit, `busy` is high for exactly 4 cycles and then falls by itself.
- R6: Any write made while `busy` is high is discarded, with no effect on the held code or on any commit. `wr_err` is high for the one cycle that follows the discarded write.
- R7: `active_mult` always equals 32 − `active_code`, which lies in the range 1..32.
- R8: During reset and just after it, `active_code` is 0 (full rate), `busy` and `wr_err` are low, and no commit is staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle control write strobe |
| wr_data | input | 32 | Write data: bit 31 is the kick, bits 4:0 are the code |
| ce_out | output | 1 | One-cycle enable for each passed parent cycle |
| busy | output | 1 | High while a commit is settling |
| wr_err | output | 1 | One-cycle flag for a discarded write |
| active_code | output | 5 | Code currently in use |
| active_mult | output | 6 | Enabled cycles per window, 32 − code |

## Verification
The bench drives commits at arbitrary window positions and on the last cycle of a window. A design that applies a new code mid-window would produce a window whose enable count matches neither the old code nor the new one. The bench writes during the busy period and then commits again. A design that let a discarded write reach the held code would activate the wrong rate, and one that dropped the error pulse or kept busy for a different length would mismatch the per-cycle model. It also checks that a plain write is not applied without a commit, that the code field of a kick write is ignored, and the extreme codes 0 and 31. An accumulator with a wrong carry or wrap shows up as a shifted pattern or a wrong count per window.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
  localparam int CODE_W = 5;
  localparam int WIN    = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CODE_W:0]   mult_t;

  // enabled cycles per window for a given code
  function automatic mult_t mult_of(code_t c);
    return mult_t'(WIN) - mult_t'(c);
  endfunction

  // accumulator increment: multiplier reduced modulo the window
  function automatic code_t step_of(code_t c);
    return code_t'(mult_of(c));
  endfunction

  // pass decision: carry out of the phase add, or full-rate code
  function automatic logic carry_of(code_t acc, code_t c);
    logic [CODE_W:0] s;
    s = {1'b0, acc} + {1'b0, step_of(c)};
    return s[CODE_W] | (c == '0);
  endfunction
endpackage

// File: rtl/pswl_cmd.sv
module pswl_cmd
  import pswl_pkg::*;
#(
  parameter int BUSY_CYC = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_valid,
  input  logic  wr_kick,
  input  code_t wr_code,
  input  logic  win_end,
  output logic  busy,
  output logic  wr_err,
  output code_t staged_code,
  output logic  staged_v
);
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  logic [BUSY_W-1:0] busy_cnt;
  code_t             held_code;

  // named events for assertions
  logic wr_reject, wr_accept, kick_accept, code_load;
  assign wr_reject   = wr_valid & busy;
  assign wr_accept   = wr_valid & ~busy;
  assign kick_accept = wr_accept & wr_kick;
  assign code_load   = wr_accept & ~wr_kick;
  assign busy        = (busy_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt    <= '0;
      held_code   <= '0;
      staged_code <= '0;
      staged_v    <= 1'b0;
      wr_err      <= 1'b0;
    end else begin
      wr_err <= wr_reject;
      if (code_load) held_code <= wr_code;
      if (kick_accept) begin
        busy_cnt    <= BUSY_W'(BUSY_CYC);
        staged_code <= held_code;
        staged_v    <= 1'b1;
      end else begin
        if (busy) busy_cnt <= busy_cnt - 1'b1;
        if (win_end) staged_v <= 1'b0;
      end
    end
  end

  AST_KICK_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    kick_accept |=> busy); // R5
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> (wr_err && $stable(held_code))); // R6
endmodule

// File: rtl/pswl_gate.sv
module pswl_gate
  import pswl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t staged_code,
  input  logic  staged_v,
  output logic  win_end,
  output code_t active_code,
  output logic  ce
);
  code_t pos;
  code_t acc;

  // named events for assertions
  logic apply_now;
  assign win_end   = (pos == code_t'(WIN - 1));
  assign apply_now = win_end & staged_v;
  assign ce        = carry_of(acc, active_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos         <= '0;
      acc         <= '0;
      active_code <= '0;
    end else begin
      pos <= pos + 1'b1;
      if (apply_now) begin
        active_code <= staged_code;
        acc         <= '0;
      end else begin
        acc <= acc + step_of(active_code);
      end
    end
  end

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_code == '0) |-> ce); // R1
  AST_APPLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(active_code)); // R4
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (acc == '0)); // R2
endmodule

// File: rtl/pulse_swallow_ce.sv
module pulse_swallow_ce
  import pswl_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int KICK_BIT = 31,
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ce_out,
  output logic              busy,
  output logic              wr_err,
  output logic [CODE_W-1:0] active_code,
  output logic [CODE_W:0]   active_mult
);
  code_t staged_code;
  logic  staged_v;
  logic  win_end;
  logic  unused_rsvd;

  // reserved bits are accepted and dropped
  assign unused_rsvd = ^wr_data;

  pswl_cmd #(.BUSY_CYC(BUSY_CYC)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_kick    (wr_data[KICK_BIT]),
    .wr_code    (wr_data[CODE_W-1:0]),
    .win_end    (win_end),
    .busy       (busy),
    .wr_err     (wr_err),
    .staged_code(staged_code),
    .staged_v   (staged_v)
  );

  pswl_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .staged_code(staged_code),
    .staged_v   (staged_v),
    .win_end    (win_end),
    .active_code(active_code),
    .ce         (ce_out)
  );

  assign active_mult = mult_of(active_code);

  AST_MULT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mult >= 7'd1) && (active_mult <= 7'd32)); // R7
endmodule

// File: tb/sim_pulse_swallow_ce.sv
module sim_pulse_swallow_ce;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ce_out, busy, wr_err;
  logic [4:0]  active_code;
  logic [5:0]  active_mult;

  pulse_swallow_ce u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .ce_out(ce_out), .busy(busy), .wr_err(wr_err),
    .active_code(active_code), .active_mult(active_mult)
  );

  int vectors = 0, bad = 0, cyc_n = 0, win_sum = 0;
  int m_act = 0, m_pend = 0, m_stg = 0, m_stv = 0, m_busy = 0, m_err = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc_n, act, exp);
    end
  endtask

  function automatic int want_ce(int n, int code);
    int k;
    k = 32 - code;
    return ((n + 1) * k) / 32 - (n * k) / 32;
  endfunction

  task automatic step(bit v, logic [31:0] d);
    int n;
    bit nerr, acc;
    @(negedge clk);
    n = cyc_n % 32;
    chk("R2 enable pattern", int'(ce_out), want_ce(n, m_act));
    chk("R5 busy", int'(busy), int'(m_busy > 0));
    chk("R6 error flag", int'(wr_err), m_err);
    chk("R4 active code", int'(active_code), m_act);
    chk("R7 multiplier", int'(active_mult), 32 - m_act);
    win_sum += int'(ce_out);
    if (n == 31) begin
      chk("R1 enables per window", win_sum, 32 - m_act);
      win_sum = 0;
    end
    rst_n = 1'b1; wr_valid = v; wr_data = d;
    nerr = v && (m_busy > 0);
    acc  = v && (m_busy == 0);
    if (n == 31 && m_stv != 0) begin m_act = m_stg; m_stv = 0; end
    if (acc && d[31]) begin m_stg = m_pend; m_stv = 1; m_busy = 4; end
    else if (m_busy > 0) m_busy--;
    if (acc && !d[31]) m_pend = int'(d[4:0]);
    m_err = int'(nerr);
    cyc_n++;
  endtask

  task automatic idle(int nc);
    for (int i = 0; i < nc; i++) step(1'b0, 32'h0);
  endtask

  // reserved bits set to a pattern to show they are ignored (R3)
  task automatic wr(bit kick, logic [4:0] code);
    step(1'b1, {kick, 26'h2AAAAAA, code});
  endtask

  task automatic to_last_slot();
    while ((cyc_n % 32) != 31) step(1'b0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset active code", int'(active_code), 0);
    chk("R8 reset busy", int'(busy), 0);
    chk("R8 reset error", int'(wr_err), 0);
    chk("R8 reset full rate", int'(ce_out), 1);
    idle(40);
    wr(1'b0, 5'd5);          // R3: held only
    idle(70);
    wr(1'b1, 5'd9);          // R4: stages 5, field 9 ignored
    wr(1'b0, 5'd20);         // R6: rejected while busy
    wr(1'b1, 5'd3);          // R6: rejected kick
    idle(70);
    wr(1'b1, 5'd0);          // restage held 5
    idle(40);
    wr(1'b0, 5'd31); idle(2); wr(1'b1, 5'd0);
    idle(80);
    wr(1'b0, 5'd16); to_last_slot(); wr(1'b1, 5'd0);  // R4 last slot
    idle(80);
    wr(1'b0, 5'd1); idle(3); wr(1'b1, 5'd0); wr(1'b1, 5'd0);
    idle(70);
    for (int r = 0; r < 60; r++) begin
      wr(1'b0, 5'($urandom_range(0, 31)));
      idle(int'($urandom_range(0, 20)));
      wr(1'b1, 5'($urandom_range(0, 31)));
      idle(int'($urandom_range(0, 45)));
    end
    wr(1'b0, 5'd0); idle(5); wr(1'b1, 5'd0);
    idle(70);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc_n);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule